// File: doc/BRIEF.md
# Single-Cycle Six-Operation Processor Core

This block is a small processor core that finishes one instruction per clock. Each clock it fetches a 12-bit word from a program ROM, decodes it, and performs exactly one of three actions. It can move a data-memory word into a register, move a register into data memory, or combine two registers in the ALU and write the result to a third. There are no branches, so the program counter steps through the ROM in order and wraps back to the start.

The program ROM and the power-up image of the data memory are elaboration parameters. A synchronous reset returns the program counter to zero, clears the eight registers and reloads the data-memory image. The ports carry a trace of every architectural write, and the surrounding logic can follow all of the core's state from that trace.

Top module: `cpu6_core`

## Requirements
- R1: While `rst_i` is high at a rising edge, the program counter goes to 0, all eight registers go to 0 and every data-memory word takes its value from `DMEM_INIT`. In the first cycle after reset, `pc_o` is 0.
- R2: When not in reset, `pc_o` increases by one on every rising edge and wraps from 63 to 0.
- R3: Opcode `000` (bits [11:9]) is a load. Bits [8:6] name the destination register and bits [5:0] give the data-memory address. The register receives that memory word, and data memory is not written.
- R4: Opcode `001` is a store. Bits [8:3] give the data-memory address and bits [2:0] name the source register. That word is written to memory, and no register is written.
- R5: For the ALU group, bits [8:6] name the destination, bits [5:3] the first operand and bits [2:0] the second. Opcode `100` writes the sum modulo 256.
- R6: Opcode `101` writes the first operand minus the second, modulo 256, so a negative result wraps.
- R7: Opcode `110` writes the bitwise AND and opcode `111` writes the bitwise OR of the two operands.
- R8: Opcodes `010` and `011` write neither a register nor data memory.
- R9: The register write and the memory write are never active in the same cycle. Register write data comes from data memory for a load and from the ALU for the four ALU opcodes.
- R10: A Fibonacci program built from these instructions leaves F(0)..F(13) at data-memory addresses 0..13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| pc_o | output | 6 | Current program counter |
| instr_o | output | 12 | Instruction word being executed |
| rf_we_o | output | 1 | Register write happens at the next edge |
| rf_waddr_o | output | 3 | Destination register |
| rf_wdata_o | output | 8 | Value being written to the register |
| dm_we_o | output | 1 | Data-memory write happens at the next edge |
| dm_addr_o | output | 6 | Data-memory address chosen by the address mux |
| dm_wdata_o | output | 8 | Value being written to data memory |

## Verification
A corrupted register or memory word stays hidden until an instruction reads it. It then appears as a wrong write value on the trace, either in that same cycle or when the value is stored. The bench therefore runs a reference model alongside the core and compares the write trace at every clock. A program-counter slip or a decode fault shows at once as a wrong `pc_o` or a wrong write enable, address or field choice in the same cycle.

// File: rtl/cpu6_pkg.sv
package cpu6_pkg;

   localparam int OPC_W = 3;

   localparam logic [OPC_W-1:0] OPC_LOAD  = 3'b000;
   localparam logic [OPC_W-1:0] OPC_STORE = 3'b001;
   localparam logic [OPC_W-1:0] OPC_SUM   = 3'b100;
   localparam logic [OPC_W-1:0] OPC_DIFF  = 3'b101;
   localparam logic [OPC_W-1:0] OPC_CONJ  = 3'b110;
   localparam logic [OPC_W-1:0] OPC_DISJ  = 3'b111;

   typedef enum logic [1:0] {
      ALU_ADD = 2'b00,
      ALU_SUB = 2'b01,
      ALU_AND = 2'b10,
      ALU_OR  = 2'b11
   } alu_op_e;

   typedef struct packed {
      logic    rf_we;
      logic    dm_we;
      alu_op_e alu_op;
      logic    addr_from_st;
      logic    wb_from_mem;
   } ctrl_t;

endpackage

// File: rtl/cpu6_ctrl.sv
module cpu6_ctrl
   import cpu6_pkg::*;
(
   input  logic [OPC_W-1:0] opcode_i,
   output ctrl_t            ctrl_o
);

   always_comb begin
      ctrl_o = '0;
      unique case (opcode_i)
         OPC_LOAD: begin
            ctrl_o.rf_we       = 1'b1;
            ctrl_o.wb_from_mem = 1'b1;
         end
         OPC_STORE: begin
            ctrl_o.dm_we        = 1'b1;
            ctrl_o.addr_from_st = 1'b1;
         end
         OPC_SUM:  begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_ADD; end
         OPC_DIFF: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SUB; end
         OPC_CONJ: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_AND; end
         OPC_DISJ: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_OR;  end
         default: ;
      endcase
   end

endmodule

// File: rtl/cpu6_alu.sv
module cpu6_alu
   import cpu6_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  alu_op_e           op_i,
   output logic [DATA_W-1:0] y_o
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("cpu6_alu: DATA_W must be positive");
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         ALU_ADD: y_o = a_i + b_i;
         ALU_SUB: y_o = a_i - b_i;
         ALU_AND: y_o = a_i & b_i;
         ALU_OR:  y_o = a_i | b_i;
         default: y_o = '0;
      endcase
   end

endmodule

// File: rtl/cpu6_regfile.sv
module cpu6_regfile #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_a_i,
   input  logic [ADDR_W-1:0] raddr_b_i,
   output logic [DATA_W-1:0] rdata_a_o,
   output logic [DATA_W-1:0] rdata_b_o
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_depth
         $error("cpu6_regfile: ADDR_W out of range");
      end
   endgenerate

   logic [DATA_W-1:0] regs [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i) begin
         if (rst_i)
            q <= '0;
         else if (we_i && waddr_i == ADDR_W'(g))
            q <= wdata_i;
      end
      assign regs[g] = q;
   end

   assign rdata_a_o = regs[raddr_a_i];
   assign rdata_b_o = regs[raddr_b_i];

   // R3 R5: a write is visible in the addressed entry one edge later
   a_r5_rf_write_lands: assert property (@(posedge clk_i) disable iff (rst_i)
      we_i |=> regs[$past(waddr_i)] == $past(wdata_i));

   // R1: registers read zero right after reset
   a_r1_rf_cleared: assert property (@(posedge clk_i)
      $fell(rst_i) |-> (rdata_a_o == '0 && rdata_b_o == '0));

endmodule

// File: rtl/cpu6_dmem.sv
module cpu6_dmem #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter logic [(1<<ADDR_W)*DATA_W-1:0] INIT = '0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_depth
         $error("cpu6_dmem: ADDR_W out of range");
      end
   endgenerate

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i) begin
         if (rst_i)
            q <= INIT[g*DATA_W +: DATA_W];
         else if (we_i && addr_i == ADDR_W'(g))
            q <= wdata_i;
      end
      assign words[g] = q;
   end

   assign rdata_o = words[addr_i];

   // R4: a stored word lands at the addressed location
   a_r4_dm_write_lands: assert property (@(posedge clk_i) disable iff (rst_i)
      we_i |=> words[$past(addr_i)] == $past(wdata_i));

endmodule

// File: rtl/cpu6_core.sv
module cpu6_core
   import cpu6_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int REG_AW  = 3,
   parameter int MEM_AW  = 6,
   parameter int IMEM_AW = 6,
   parameter logic [(1<<IMEM_AW)*(OPC_W+3*REG_AW)-1:0] PROGRAM   = '0,
   parameter logic [(1<<MEM_AW)*DATA_W-1:0]             DMEM_INIT = '0
) (
   input  logic                clk_i,
   input  logic                rst_i,
   output logic [IMEM_AW-1:0]  pc_o,
   output logic [OPC_W+3*REG_AW-1:0] instr_o,
   output logic                rf_we_o,
   output logic [REG_AW-1:0]   rf_waddr_o,
   output logic [DATA_W-1:0]   rf_wdata_o,
   output logic                dm_we_o,
   output logic [MEM_AW-1:0]   dm_addr_o,
   output logic [DATA_W-1:0]   dm_wdata_o
);

   localparam int INSTR_W    = OPC_W + 3*REG_AW;
   localparam int IMEM_DEPTH = 1 << IMEM_AW;

   generate
      if (OPC_W + MEM_AW + REG_AW != INSTR_W) begin : g_bad_format
         $error("cpu6_core: memory and register fields do not fill the word");
      end
   endgenerate

   // program counter
   logic [IMEM_AW-1:0] pc_q;
   always_ff @(posedge clk_i) begin
      if (rst_i) pc_q <= '0;
      else       pc_q <= pc_q + IMEM_AW'(1);
   end

   // instruction ROM
   logic [INSTR_W-1:0] imem [IMEM_DEPTH];
   for (genvar g = 0; g < IMEM_DEPTH; g++) begin : g_rom
      assign imem[g] = PROGRAM[g*INSTR_W +: INSTR_W];
   end
   logic [INSTR_W-1:0] instr;
   assign instr = imem[pc_q];

   // field split
   logic [OPC_W-1:0]  opcode;
   logic [REG_AW-1:0] f_dst, f_srca, f_srcb;
   logic [MEM_AW-1:0] f_ld_addr, f_st_addr;
   assign opcode    = instr[INSTR_W-1 -: OPC_W];
   assign f_dst     = instr[3*REG_AW-1 -: REG_AW];
   assign f_srca    = instr[2*REG_AW-1 -: REG_AW];
   assign f_srcb    = instr[REG_AW-1:0];
   assign f_ld_addr = instr[MEM_AW-1:0];
   assign f_st_addr = instr[MEM_AW+REG_AW-1 -: MEM_AW];

   ctrl_t ctrl;
   cpu6_ctrl i_ctrl (.opcode_i(opcode), .ctrl_o(ctrl));

   logic [DATA_W-1:0] opa, opb, alu_y, dm_rdata, wb_data;
   logic [MEM_AW-1:0] dm_addr;

   cpu6_regfile #(.DATA_W(DATA_W), .ADDR_W(REG_AW)) i_rf (
      .clk_i(clk_i), .rst_i(rst_i),
      .we_i(ctrl.rf_we), .waddr_i(f_dst), .wdata_i(wb_data),
      .raddr_a_i(f_srca), .raddr_b_i(f_srcb),
      .rdata_a_o(opa), .rdata_b_o(opb)
   );

   cpu6_alu #(.DATA_W(DATA_W)) i_alu (
      .a_i(opa), .b_i(opb), .op_i(ctrl.alu_op), .y_o(alu_y)
   );

   assign dm_addr = ctrl.addr_from_st ? f_st_addr : f_ld_addr;

   cpu6_dmem #(.DATA_W(DATA_W), .ADDR_W(MEM_AW), .INIT(DMEM_INIT)) i_dmem (
      .clk_i(clk_i), .rst_i(rst_i),
      .we_i(ctrl.dm_we), .addr_i(dm_addr), .wdata_i(opb),
      .rdata_o(dm_rdata)
   );

   assign wb_data = ctrl.wb_from_mem ? dm_rdata : alu_y;

   assign pc_o       = pc_q;
   assign instr_o    = instr;
   assign rf_we_o    = ctrl.rf_we;
   assign rf_waddr_o = f_dst;
   assign rf_wdata_o = wb_data;
   assign dm_we_o    = ctrl.dm_we;
   assign dm_addr_o  = dm_addr;
   assign dm_wdata_o = opb;

   // R2: counter advances by one each clock out of reset
   a_r2_pc_step: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> pc_q == $past(pc_q) + IMEM_AW'(1));

   // R1: first cycle after reset starts at address zero
   a_r1_pc_zero: assert property (@(posedge clk_i)
      $fell(rst_i) |-> pc_q == '0);

   // R9: never a register write and a memory write together
   a_r9_one_write: assert property (@(posedge clk_i) disable iff (rst_i)
      !(rf_we_o && dm_we_o));

   // R8: spare opcodes leave all state alone
   a_r8_spare_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
      (opcode[2:1] == 2'b01) |-> (!rf_we_o && !dm_we_o));

   // R3 R9: load takes memory data from the low address field
   a_r3_load_path: assert property (@(posedge clk_i) disable iff (rst_i)
      (opcode == OPC_LOAD) |-> (dm_addr_o == instr[MEM_AW-1:0] && rf_wdata_o == dm_rdata));

endmodule

// File: tb/test_cpu6_core.sv
`timescale 1ns/1ps
module test_cpu6_core;

   localparam int NW = 64;
   localparam int IW = 12;

   function automatic logic [IW-1:0] e_ld(input int ra, input int ad);
      return {3'b000, 3'(ra), 6'(ad)};
   endfunction
   function automatic logic [IW-1:0] e_st(input int ad, input int rc);
      return {3'b001, 6'(ad), 3'(rc)};
   endfunction
   function automatic logic [IW-1:0] e_alu(input logic [2:0] op, input int ra, input int rb, input int rc);
      return {op, 3'(ra), 3'(rb), 3'(rc)};
   endfunction

   function automatic logic [NW*IW-1:0] build_prog();
      logic [IW-1:0] p [NW];
      logic [NW*IW-1:0] v;
      for (int i = 0; i < NW; i++) p[i] = 12'h000 | 12'b010_000_000_000;
      p[0] = e_ld(1, 0);
      p[1] = e_ld(2, 1);
      for (int k = 2; k <= 13; k++) begin
         p[2+4*(k-2)]   = e_alu(3'b100, 3, 1, 2);
         p[2+4*(k-2)+1] = e_st(k, 3);
         p[2+4*(k-2)+2] = e_alu(3'b111, 1, 2, 2);
         p[2+4*(k-2)+3] = e_alu(3'b111, 2, 3, 3);
      end
      p[50] = e_alu(3'b101, 4, 1, 3);
      p[51] = e_st(50, 4);
      p[52] = e_alu(3'b110, 5, 1, 3);
      p[53] = e_st(51, 5);
      p[54] = e_alu(3'b111, 6, 1, 2);
      p[55] = e_st(52, 6);
      p[56] = 12'b010_111_101_011;
      p[57] = e_ld(7, 40);
      p[58] = e_st(53, 7);
      p[59] = 12'b011_110_110_111;
      for (int i = 0; i < NW; i++) v[i*IW +: IW] = p[i];
      return v;
   endfunction

   function automatic logic [NW*8-1:0] build_init();
      logic [NW*8-1:0] v;
      v = '0;
      v[1*8 +: 8]  = 8'd1;
      v[40*8 +: 8] = 8'hA5;
      return v;
   endfunction

   localparam logic [NW*IW-1:0] PROG = build_prog();
   localparam logic [NW*8-1:0]  INIT = build_init();

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [5:0]  pc;
   logic [11:0] instr;
   logic        rf_we, dm_we;
   logic [2:0]  rf_waddr;
   logic [7:0]  rf_wdata, dm_wdata;
   logic [5:0]  dm_addr;

   cpu6_core #(.PROGRAM(PROG), .DMEM_INIT(INIT)) i_cpu6_core (
      .clk_i(clk), .rst_i(rst),
      .pc_o(pc), .instr_o(instr),
      .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
      .dm_we_o(dm_we), .dm_addr_o(dm_addr), .dm_wdata_o(dm_wdata)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int m_pc;
   int m_reg [8];
   int m_mem [NW];
   int seen_mem [NW];

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_pc = 0;
      for (int i = 0; i < 8; i++) m_reg[i] = 0;
      for (int i = 0; i < NW; i++) begin
         m_mem[i]    = int'(INIT[i*8 +: 8]);
         seen_mem[i] = m_mem[i];
      end
   endtask

   // compare one cycle at the negedge, then advance the model
   task automatic step_compare();
      logic [11:0] w;
      int op, ra, rb, rc, lda, sta, res, ex_rf, ex_dm;
      string tag;
      w   = PROG[m_pc*IW +: IW];
      op  = int'(w[11:9]);
      ra  = int'(w[8:6]);
      rb  = int'(w[5:3]);
      rc  = int'(w[2:0]);
      lda = int'(w[5:0]);
      sta = int'(w[8:3]);
      ex_rf = 0; ex_dm = 0; res = 0; tag = "R8";
      case (op)
         0: begin ex_rf = 1; res = m_mem[lda]; tag = "R3"; end
         1: begin ex_dm = 1; tag = "R4"; end
         4: begin ex_rf = 1; res = (m_reg[rb] + m_reg[rc]) % 256; tag = "R5"; end
         5: begin ex_rf = 1; res = (m_reg[rb] - m_reg[rc] + 256) % 256; tag = "R6"; end
         6: begin ex_rf = 1; res = m_reg[rb] & m_reg[rc]; tag = "R7"; end
         7: begin ex_rf = 1; res = m_reg[rb] | m_reg[rc]; tag = "R7"; end
         default: ;
      endcase
      chk(int'(pc) == m_pc, "R2", "pc", int'(pc), m_pc);
      chk(int'(rf_we) == ex_rf, tag, "reg write enable", int'(rf_we), ex_rf);
      chk(int'(dm_we) == ex_dm, tag, "mem write enable", int'(dm_we), ex_dm);
      chk(!(rf_we && dm_we), "R9", "both writes", int'(rf_we) + int'(dm_we), 1);
      if (ex_rf == 1) begin
         chk(int'(rf_waddr) == ra, tag, "dest reg", int'(rf_waddr), ra);
         chk(int'(rf_wdata) == res, tag, "write data", int'(rf_wdata), res);
      end
      if (ex_dm == 1) begin
         chk(int'(dm_addr) == sta, "R4", "store addr", int'(dm_addr), sta);
         chk(int'(dm_wdata) == m_reg[rc], "R4", "store data", int'(dm_wdata), m_reg[rc]);
      end
      // observed memory from the write trace
      if (dm_we) seen_mem[dm_addr] = int'(dm_wdata);
      // model update
      if (ex_rf == 1) m_reg[ra] = res;
      if (ex_dm == 1) m_mem[sta] = m_reg[rc];
      m_pc = (m_pc + 1) % NW;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int fa, fb, ft;
      model_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk(pc == 6'd0, "R1", "pc after reset", int'(pc), 0);
      for (int c = 0; c < 140; c++) begin
         step_compare();
         @(posedge clk);
         @(negedge clk);
      end
      // R10: Fibonacci values from the write trace
      fa = 0; fb = 1;
      for (int k = 0; k <= 13; k++) begin
         chk(seen_mem[k] == fa, "R10", $sformatf("fib word %0d", k), seen_mem[k], fa);
         ft = fa + fb; fa = fb; fb = ft;
      end
      chk(seen_mem[50] == 167, "R6", "wrapped difference", seen_mem[50], 167);
      chk(seen_mem[51] == 128, "R7", "and result", seen_mem[51], 128);
      chk(seen_mem[52] == 249, "R7", "or result", seen_mem[52], 249);
      chk(seen_mem[53] == 165, "R3", "loaded preset word", seen_mem[53], 165);
      // R1: mid-run reset restarts everything
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      chk(pc == 6'd0, "R1", "pc after second reset", int'(pc), 0);
      for (int c = 0; c < 8; c++) begin
         step_compare();
         @(posedge clk);
         @(negedge clk);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule